// File: doc/BRIEF.md
# AES Round Key Store

This block turns an AES cipher key into its full round-key schedule once, at the moment the key is committed. It then holds the schedule so that encryption and decryption passes can draw round keys repeatedly without any further expansion work. Key material enters as a stream of words. Each command on a two-bit update input either parks the upper half of a 256-bit key or commits the key and launches expansion. During expansion the block forms one complete 128-bit round key per clock.

A consumer starts a pass with a direction bit. A low direction gives ascending order, round key 0 first, which suits encryption. A high direction gives descending order, last round key first, which suits decryption. Each pulse on the advance input then steps to the next key. The two ready flags stay low during expansion and rise together once the schedule is complete. A parameter can drop 256-bit support, which shrinks the store from fifteen entries to eleven.

Top module: `aes_rk_store`

## Requirements
- R1: Each cycle with `key_wr_valid` high shifts one 32-bit word into a 128-bit staging value. The word written earliest of the last four occupies bits [127:96] and the newest occupies bits [31:0].
- R2: `upd_cmd` = 2 copies the staging value into the upper-half holder. `upd_cmd` = 1 commits the key and starts expansion. `mode_256` is sampled only in the `upd_cmd` = 1 cycle (1 selects a 256-bit key built from holder and staging value, 0 a 128-bit key taken from the staging value).
- R3: `upd_cmd` = 0 and `upd_cmd` = 3 change nothing: the flags and the presented key stay as they were.
- R4: The schedule follows the standard AES expansion. A 128-bit key gives 11 round keys, key 0 being the key itself. A 256-bit key gives 15 round keys, key 0 being the upper half and key 1 the lower half.
- R5: `enc_ready` and `dec_ready` rise together exactly 10 cycles (128-bit) or 13 cycles (256-bit) after the clock edge that takes the commit.
- R6: Either update command (1 or 2) drops both flags at the next edge and abandons any expansion under way. A 1 restarts expansion from the new key, and a 2 leaves the flags low.
- R7: While the flags are low, `rk_out` is zero and `pass_start` and `rk_next` have no effect.
- R8: When the flags rise, `rk_out` shows round key 0 and the sequence is ascending.
- R9: `pass_start` with `pass_dir` = 0 presents key 0 after the edge. With `pass_dir` = 1 it presents the last key. Each `rk_next` then steps one key in the chosen direction, wrapping from the last key to 0 (ascending) or from 0 to the last key (descending).
- R10: When `pass_start` and `rk_next` are high in the same cycle, `pass_start` wins and no extra step is taken.
- R11: The schedule and its key count stay unchanged across any number of passes and any later change of `mode_256` until the next commit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| key_wr_valid | input | 1 | Shift `key_wr_data` into the staging value |
| key_wr_data | input | 32 | Key word, most significant first |
| mode_256 | input | 1 | Key size for the commit: 1 = 256-bit, 0 = 128-bit |
| upd_cmd | input | 2 | 1 = commit and expand, 2 = hold upper half, others = none |
| pass_start | input | 1 | Begin a pass in direction `pass_dir` |
| pass_dir | input | 1 | 0 = ascending, 1 = descending |
| rk_next | input | 1 | Step to the next round key |
| rk_out | output | 128 | Presented round key (zero when not ready) |
| enc_ready | output | 1 | Schedule available for encryption |
| dec_ready | output | 1 | Schedule available for decryption |

## Verification
Two pairs of functions collide in a single cycle. A pass restart can meet a step request, and an update command can meet an expansion in progress. The bench first moves the pointer away from key 0. It then raises `pass_start` and `rk_next` together in both directions and expects the head of the pass, not its neighbour. It also pushes a second key and commits it part-way through an expansion. The result passes only if the latency counts from the second commit and every round key matches the second key's reference schedule.

// File: rtl/aes_rk_pkg.sv
package aes_rk_pkg;

   localparam int RK_W = 128;

   localparam logic [1:0] CMD_COMMIT = 2'd1;
   localparam logic [1:0] CMD_UPPER  = 2'd2;

   function automatic logic [7:0] gf_xtime(input logic [7:0] a);
      return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
   endfunction

   function automatic logic [7:0] gf_mul(input logic [7:0] a, input logic [7:0] b);
      logic [7:0] acc;
      logic [7:0] run;
      acc = 8'h00;
      run = a;
      for (int i = 0; i < 8; i++) begin
         if (b[i]) acc = acc ^ run;
         run = gf_xtime(run);
      end
      return acc;
   endfunction

   // multiplicative inverse as a^254, then the affine map
   function automatic logic [7:0] sbox_calc(input logic [7:0] a);
      logic [7:0] e2, e3, e12, e15, e240, inv;
      e2   = gf_mul(a, a);
      e3   = gf_mul(e2, a);
      e12  = gf_mul(gf_mul(e3, e3), gf_mul(e3, e3));
      e15  = gf_mul(e12, e3);
      e240 = gf_mul(e15, e15);
      e240 = gf_mul(e240, e240);
      e240 = gf_mul(e240, e240);
      e240 = gf_mul(e240, e240);
      inv  = gf_mul(gf_mul(e240, e12), e2);
      return inv ^ {inv[6:0], inv[7]} ^ {inv[5:0], inv[7:6]}
                 ^ {inv[4:0], inv[7:5]} ^ {inv[3:0], inv[7:4]} ^ 8'h63;
   endfunction

endpackage

// File: rtl/aes_rk_sbox.sv
module aes_rk_sbox (
   input  logic [7:0] din,
   output logic [7:0] dout
);
   import aes_rk_pkg::*;

   assign dout = sbox_calc(din);

endmodule

// File: rtl/aes_rk_step.sv
module aes_rk_step
   import aes_rk_pkg::*;
#(
   parameter int KEY_W  = 128,
   parameter int WORD_W = 32
) (
   input  logic [KEY_W-1:0] prev1,
   input  logic [KEY_W-1:0] prev2,
   input  logic             use_prev2,
   input  logic             rcon_step,
   input  logic [7:0]       rcon,
   output logic [KEY_W-1:0] nxt
);
   localparam int NWORDS = KEY_W / WORD_W;
   localparam int NBYTES = WORD_W / 8;

   logic [WORD_W-1:0] tail;
   logic [WORD_W-1:0] subbed;
   logic [WORD_W-1:0] mixed;
   logic [KEY_W-1:0]  base;

   assign tail = prev1[WORD_W-1:0];

   for (genvar b = 0; b < NBYTES; b++) begin : g_sbox
      aes_rk_sbox i_sbox (
         .din  (tail[8*b +: 8]),
         .dout (subbed[8*b +: 8])
      );
   end

   // rotate-then-substitute equals substitute-then-rotate
   assign mixed = rcon_step
                ? ({subbed[WORD_W-9:0], subbed[WORD_W-1 -: 8]} ^ {rcon, {(WORD_W-8){1'b0}}})
                : subbed;

   assign base = use_prev2 ? prev2 : prev1;

   always_comb begin
      logic [WORD_W-1:0] carry;
      carry = mixed;
      for (int w = NWORDS - 1; w >= 0; w--) begin
         carry = carry ^ base[w*WORD_W +: WORD_W];
         nxt[w*WORD_W +: WORD_W] = carry;
      end
   end

endmodule

// File: rtl/aes_rk_loader.sv
module aes_rk_loader #(
   parameter int KEY_W  = 128,
   parameter int WORD_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_valid,
   input  logic [WORD_W-1:0] wr_data,
   input  logic              latch_hi,
   output logic [KEY_W-1:0]  stage_q,
   output logic [KEY_W-1:0]  hi_q
);
   localparam int WORDS = KEY_W / WORD_W;

   if (WORDS == 1) begin : g_single
      always_ff @(posedge clk) begin
         if (!rst_n)        stage_q <= '0;
         else if (wr_valid) stage_q <= wr_data;
      end
   end else begin : g_shift
      always_ff @(posedge clk) begin
         if (!rst_n)        stage_q <= '0;
         else if (wr_valid) stage_q <= {stage_q[KEY_W-WORD_W-1:0], wr_data};
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)        hi_q <= '0;
      else if (latch_hi) hi_q <= stage_q;
   end

endmodule

// File: rtl/aes_rk_bank.sv
module aes_rk_bank #(
   parameter int NKEYS = 15,
   parameter int KEY_W = 128,
   parameter int IW    = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             seed_en,
   input  logic             seed_two,
   input  logic [KEY_W-1:0] seed0,
   input  logic [KEY_W-1:0] seed1,
   input  logic             wr_en,
   input  logic [IW-1:0]    wr_idx,
   input  logic [KEY_W-1:0] wr_data,
   input  logic [IW-1:0]    last_idx,
   input  logic             arm,
   input  logic             seq_en,
   input  logic             pass_start,
   input  logic             pass_dir,
   input  logic             adv,
   output logic [KEY_W-1:0] rd_key
);
   logic [KEY_W-1:0] kv [NKEYS];
   logic [IW-1:0]    ptr_q;
   logic             dir_q;

   always_ff @(posedge clk) begin
      if (seed_en) begin
         kv[0] <= seed0;
         if (seed_two) kv[1] <= seed1;
      end else if (wr_en) begin
         kv[wr_idx] <= wr_data;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ptr_q <= '0;
         dir_q <= 1'b0;
      end else if (arm) begin
         ptr_q <= '0;
         dir_q <= 1'b0;
      end else if (seq_en) begin
         if (pass_start) begin
            dir_q <= pass_dir;
            ptr_q <= pass_dir ? last_idx : '0;
         end else if (adv) begin
            if (!dir_q) ptr_q <= (ptr_q == last_idx) ? '0 : ptr_q + 1'b1;
            else        ptr_q <= (ptr_q == '0) ? last_idx : ptr_q - 1'b1;
         end
      end
   end

   assign rd_key = kv[ptr_q];

endmodule

// File: rtl/aes_rk_store.sv
module aes_rk_store
   import aes_rk_pkg::*;
#(
   parameter int WORD_W      = 32,
   parameter int SUPPORT_256 = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              key_wr_valid,
   input  logic [WORD_W-1:0] key_wr_data,
   input  logic              mode_256,
   input  logic [1:0]        upd_cmd,
   input  logic              pass_start,
   input  logic              pass_dir,
   input  logic              rk_next,
   output logic [RK_W-1:0]   rk_out,
   output logic              enc_ready,
   output logic              dec_ready
);
   localparam int NKEYS   = (SUPPORT_256 != 0) ? 15 : 11;
   localparam int IW      = $clog2(NKEYS);
   localparam int STEP_W  = 4;

   if (WORD_W < 8 || (RK_W % WORD_W) != 0 || (WORD_W % 8) != 0) begin : g_bad_word
      $error("aes_rk_store: WORD_W must be a byte multiple dividing 128");
   end
   if (SUPPORT_256 != 0 && SUPPORT_256 != 1) begin : g_bad_opt
      $error("aes_rk_store: SUPPORT_256 must be 0 or 1");
   end

   logic              mode_eff;
   logic              commit, upper;
   logic              busy_q, ready_q, mode_q;
   logic [STEP_W-1:0] step_q;
   logic [7:0]        rcon_q;
   logic [RK_W-1:0]   prev1_q, prev2_q, nxt;
   logic [RK_W-1:0]   stage, hi;
   logic [RK_W-1:0]   bank_key;
   logic              rcon_step, final_step;
   logic [IW-1:0]     wr_idx, last_idx;

   if (SUPPORT_256 != 0) begin : g_wide
      assign mode_eff = mode_256;
   end else begin : g_narrow
      assign mode_eff = 1'b0;
   end

   assign commit     = (upd_cmd == CMD_COMMIT);
   assign upper      = (upd_cmd == CMD_UPPER);
   assign rcon_step  = !mode_q || !step_q[0];
   assign final_step = busy_q && (step_q == (mode_q ? STEP_W'(12) : STEP_W'(9)));
   assign wr_idx     = IW'(step_q) + (mode_q ? IW'(2) : IW'(1));
   assign last_idx   = mode_q ? IW'(14) : IW'(10);

   aes_rk_loader #(.KEY_W(RK_W), .WORD_W(WORD_W)) i_loader (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_valid (key_wr_valid),
      .wr_data  (key_wr_data),
      .latch_hi (upper),
      .stage_q  (stage),
      .hi_q     (hi)
   );

   aes_rk_step #(.KEY_W(RK_W), .WORD_W(WORD_W)) i_step (
      .prev1     (prev1_q),
      .prev2     (prev2_q),
      .use_prev2 (mode_q),
      .rcon_step (rcon_step),
      .rcon      (rcon_q),
      .nxt       (nxt)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q  <= 1'b0;
         ready_q <= 1'b0;
         mode_q  <= 1'b0;
         step_q  <= '0;
         rcon_q  <= 8'h00;
         prev1_q <= '0;
         prev2_q <= '0;
      end else if (commit) begin
         busy_q  <= 1'b1;
         ready_q <= 1'b0;
         mode_q  <= mode_eff;
         step_q  <= '0;
         rcon_q  <= 8'h01;
         prev1_q <= stage;
         prev2_q <= hi;
      end else if (upper) begin
         busy_q  <= 1'b0;
         ready_q <= 1'b0;
      end else if (busy_q) begin
         prev2_q <= prev1_q;
         prev1_q <= nxt;
         step_q  <= step_q + 1'b1;
         if (rcon_step) rcon_q <= gf_xtime(rcon_q);
         if (final_step) begin
            busy_q  <= 1'b0;
            ready_q <= 1'b1;
         end
      end
   end

   aes_rk_bank #(.NKEYS(NKEYS), .KEY_W(RK_W), .IW(IW)) i_bank (
      .clk        (clk),
      .rst_n      (rst_n),
      .seed_en    (commit),
      .seed_two   (mode_eff),
      .seed0      (mode_eff ? hi : stage),
      .seed1      (stage),
      .wr_en      (busy_q && !upper),
      .wr_idx     (wr_idx),
      .wr_data    (nxt),
      .last_idx   (last_idx),
      .arm        (final_step && !upper),
      .seq_en     (ready_q && !commit && !upper),
      .pass_start (pass_start),
      .pass_dir   (pass_dir),
      .adv        (rk_next),
      .rd_key     (bank_key)
   );

   assign rk_out    = ready_q ? bank_key : '0;
   assign enc_ready = ready_q;
   assign dec_ready = ready_q;

endmodule

// File: rtl/rk_store_chk.sv
module rk_store_chk #(
   parameter int SUPPORT_256 = 1
) (
   input logic         clk,
   input logic         rst_n,
   input logic         mode_256,
   input logic [1:0]   upd_cmd,
   input logic         pass_start,
   input logic         pass_dir,
   input logic         rk_next,
   input logic [127:0] rk_out,
   input logic         enc_ready
);
   logic         armed, mode_c, ready_d;
   logic [4:0]   lat_cnt;
   logic [127:0] head_key;
   logic [4:0]   exp_lat;
   logic         cmd_any;

   assign cmd_any = (upd_cmd == 2'd1) || (upd_cmd == 2'd2);
   assign exp_lat = (SUPPORT_256 != 0 && mode_c) ? 5'd13 : 5'd10;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         armed    <= 1'b0;
         mode_c   <= 1'b0;
         lat_cnt  <= '0;
         ready_d  <= 1'b0;
         head_key <= '0;
      end else begin
         ready_d <= enc_ready;
         if (enc_ready && !ready_d) head_key <= rk_out;
         if (upd_cmd == 2'd1) begin
            armed   <= 1'b1;
            mode_c  <= mode_256;
            lat_cnt <= '0;
         end else if (upd_cmd == 2'd2) begin
            armed <= 1'b0;
         end else if (enc_ready) begin
            armed <= 1'b0;
         end else if (armed && lat_cnt != 5'd31) begin
            lat_cnt <= lat_cnt + 1'b1;
         end
      end
   end

   AST_CMD_DROPS_READY: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_any |=> !enc_ready); // R6

   AST_READY_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(enc_ready) |-> (armed && lat_cnt == exp_lat)); // R5

   AST_KEY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (enc_ready && !rk_next && !pass_start && !cmd_any) |=> $stable(rk_out)); // R11

   AST_PASS_HEAD: assert property (@(posedge clk) disable iff (!rst_n)
      (enc_ready && pass_start && !pass_dir && !cmd_any) |=> (rk_out == head_key)); // R9

   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (!enc_ready && !$rose(enc_ready)) |-> (rk_out == '0)); // R7

endmodule

bind aes_rk_store rk_store_chk #(.SUPPORT_256(SUPPORT_256)) i_rk_store_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .mode_256   (mode_256),
   .upd_cmd    (upd_cmd),
   .pass_start (pass_start),
   .pass_dir   (pass_dir),
   .rk_next    (rk_next),
   .rk_out     (rk_out),
   .enc_ready  (enc_ready)
);

// File: tb/test_aes_rk_store.sv
module test_aes_rk_store;

   logic         clk = 1'b0;
   logic         rst_n;
   logic         key_wr_valid;
   logic [31:0]  key_wr_data;
   logic         mode_256;
   logic [1:0]   upd_cmd;
   logic         pass_start, pass_dir, rk_next;
   logic [127:0] rk_out;
   logic         enc_ready, dec_ready;

   always #5 clk = ~clk;

   aes_rk_store i_aes_rk_store (
      .clk          (clk),
      .rst_n        (rst_n),
      .key_wr_valid (key_wr_valid),
      .key_wr_data  (key_wr_data),
      .mode_256     (mode_256),
      .upd_cmd      (upd_cmd),
      .pass_start   (pass_start),
      .pass_dir     (pass_dir),
      .rk_next      (rk_next),
      .rk_out       (rk_out),
      .enc_ready    (enc_ready),
      .dec_ready    (dec_ready)
   );

   int           total = 0;
   int           bad   = 0;
   bit           finished = 0;
   logic [7:0]   sb [256];
   logic [127:0] exp_rk [15];
   int           nkeys;
   logic [31:0]  lfsr = 32'h1357_9bdf;

   task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] expv);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, expv);
      end
   endtask

   function automatic logic [31:0] rnd();
      lfsr = lfsr ^ (lfsr << 13);
      lfsr = lfsr ^ (lfsr >> 17);
      lfsr = lfsr ^ (lfsr << 5);
      return lfsr;
   endfunction

   function automatic logic [31:0] subw(input logic [31:0] w);
      return {sb[w[31:24]], sb[w[23:16]], sb[w[15:8]], sb[w[7:0]]};
   endfunction

   // reference schedule, word by word
   task automatic ref_expand(input logic [127:0] hi, input logic [127:0] lo, input bit m);
      logic [31:0] w [60];
      logic [31:0] t;
      logic [7:0]  rc;
      int nk, nw;
      nk = m ? 8 : 4;
      nw = m ? 60 : 44;
      nkeys = nw / 4;
      for (int i = 0; i < 4; i++) begin
         if (m) begin
            w[i]   = hi[127-32*i -: 32];
            w[i+4] = lo[127-32*i -: 32];
         end else begin
            w[i] = lo[127-32*i -: 32];
         end
      end
      rc = 8'h01;
      for (int i = nk; i < nw; i++) begin
         t = w[i-1];
         if (i % nk == 0) begin
            t = subw({t[23:0], t[31:24]}) ^ {rc, 24'h0};
            rc = {rc[6:0], 1'b0} ^ (rc[7] ? 8'h1b : 8'h00);
         end else if (nk == 8 && i % 8 == 4) begin
            t = subw(t);
         end
         w[i] = w[i-nk] ^ t;
      end
      for (int k = 0; k < nkeys; k++) exp_rk[k] = {w[4*k], w[4*k+1], w[4*k+2], w[4*k+3]};
   endtask

   task automatic push_key(input logic [127:0] k);
      for (int i = 0; i < 4; i++) begin
         key_wr_valid = 1'b1;
         key_wr_data  = k[127-32*i -: 32];
         @(negedge clk);
      end
      key_wr_valid = 1'b0;
   endtask

   task automatic commit(input logic [1:0] c, input bit m);
      upd_cmd  = c;
      mode_256 = m;
      @(negedge clk);
      upd_cmd  = 2'd0;
      mode_256 = 1'b0;
   endtask

   task automatic wait_ready(output int cnt);
      cnt = 0;
      while (!enc_ready && cnt < 60) begin
         @(negedge clk);
         cnt++;
      end
   endtask

   task automatic check_lat(input int cnt, input int expc, input string tag);
      chk(cnt == expc, tag, 128'(cnt), 128'(expc));
      chk(dec_ready == enc_ready, {tag, " flags together"}, 128'(dec_ready), 128'(enc_ready));
   endtask

   // R9: full pass plus one wrap step
   task automatic check_pass(input bit dir, input string tag);
      int idx;
      pass_start = 1'b1;
      pass_dir   = dir;
      @(negedge clk);
      pass_start = 1'b0;
      for (int k = 0; k <= nkeys; k++) begin
         idx = dir ? (nkeys - 1 - (k % nkeys)) : (k % nkeys);
         chk(rk_out == exp_rk[idx], tag, rk_out, exp_rk[idx]);
         rk_next = 1'b1;
         @(negedge clk);
         rk_next = 1'b0;
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         total++;
         bad++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      logic [7:0]   p, q, x;
      logic [127:0] held, ka, kb;
      int cnt;

      p = 8'h01;
      q = 8'h01;
      for (int i = 0; i < 255; i++) begin
         p = p ^ {p[6:0], 1'b0} ^ (p[7] ? 8'h1b : 8'h00);
         q = q ^ {q[6:0], 1'b0};
         q = q ^ {q[5:0], 2'b0};
         q = q ^ {q[3:0], 4'b0};
         if (q[7]) q = q ^ 8'h09;
         x = q ^ {q[6:0], q[7]} ^ {q[5:0], q[7:6]} ^ {q[4:0], q[7:5]} ^ {q[3:0], q[7:4]};
         sb[p] = x ^ 8'h63;
      end
      sb[0] = 8'h63;

      rst_n = 1'b0;
      key_wr_valid = 1'b0; key_wr_data = '0; mode_256 = 1'b0; upd_cmd = 2'd0;
      pass_start = 1'b0; pass_dir = 1'b0; rk_next = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      chk(!enc_ready && !dec_ready, "R7 reset flags", {126'd0, enc_ready, dec_ready}, '0);
      chk(rk_out == '0, "R7 reset key", rk_out, '0);

      // 128-bit known vector, with requests during expansion
      ka = 128'h2b7e1516_28aed2a6_abf71588_09cf4f3c;
      ref_expand('0, ka, 1'b0);
      push_key(ka);
      commit(2'd1, 1'b0);
      chk(rk_out == '0 && !enc_ready, "R7 quiet during expansion", rk_out, '0);
      rk_next = 1'b1; pass_start = 1'b1; pass_dir = 1'b1;
      @(negedge clk);
      rk_next = 1'b0; pass_start = 1'b0; pass_dir = 1'b0;
      wait_ready(cnt);
      check_lat(cnt + 1, 10, "R5 latency 128");
      chk(rk_out == ka, "R1 R8 key0 word order", rk_out, ka);
      chk(exp_rk[10] == 128'hd014f9a8_c9ee2589_e13f0cc8_b6630ca6, "R4 ref last key 128", exp_rk[10],
          128'hd014f9a8_c9ee2589_e13f0cc8_b6630ca6);
      check_pass(1'b0, "R4 R9 ascending 128");
      check_pass(1'b1, "R9 descending 128");

      // 256-bit known vector, mode only asserted with the commit (R2)
      ka = 128'h603deb10_15ca71be_2b73aef0_857d7781;
      kb = 128'h1f352c07_3b6108d7_2d9810a3_0914dff4;
      ref_expand(ka, kb, 1'b1);
      push_key(ka);
      commit(2'd2, 1'b0);
      push_key(kb);
      commit(2'd1, 1'b1);
      wait_ready(cnt);
      check_lat(cnt, 13, "R5 latency 256");
      chk(rk_out == ka, "R2 R8 upper half is key0", rk_out, ka);
      chk(exp_rk[14] == 128'hfe4890d1_e6188d0b_046df344_706c631e, "R4 ref last key 256", exp_rk[14],
          128'hfe4890d1_e6188d0b_046df344_706c631e);
      check_pass(1'b0, "R2 R4 ascending 256");
      check_pass(1'b1, "R9 descending 256");

      // R11: passes repeat, mode_256 changes ignored after commit
      mode_256 = 1'b0;
      check_pass(1'b0, "R11 repeat pass 256");
      mode_256 = 1'b1;
      check_pass(1'b1, "R11 repeat pass 256 mode toggled");
      mode_256 = 1'b0;

      // R10: restart beats step, both directions
      for (int i = 0; i < 3; i++) begin
         rk_next = 1'b1; @(negedge clk); rk_next = 1'b0;
      end
      pass_start = 1'b1; pass_dir = 1'b0; rk_next = 1'b1;
      @(negedge clk);
      pass_start = 1'b0; rk_next = 1'b0;
      chk(rk_out == exp_rk[0], "R10 start wins ascending", rk_out, exp_rk[0]);
      rk_next = 1'b1; @(negedge clk); rk_next = 1'b0;
      pass_start = 1'b1; pass_dir = 1'b1; rk_next = 1'b1;
      @(negedge clk);
      pass_start = 1'b0; pass_dir = 1'b0; rk_next = 1'b0;
      chk(rk_out == exp_rk[14], "R10 start wins descending", rk_out, exp_rk[14]);

      // R3: code 3 is inert
      held = rk_out;
      push_key(128'hdead_beef_0000_1111_2222_3333_4444_5555);
      commit(2'd3, 1'b0);
      repeat (15) @(negedge clk);
      chk(enc_ready && dec_ready, "R3 code 3 keeps flags", {126'd0, enc_ready, dec_ready}, 128'd3);
      chk(rk_out == held, "R3 code 3 keeps key", rk_out, held);

      // R6: code 2 drops readiness and it stays low
      commit(2'd2, 1'b0);
      chk(!enc_ready && !dec_ready, "R6 code 2 drops flags", {126'd0, enc_ready, dec_ready}, '0);
      repeat (20) @(negedge clk);
      chk(!enc_ready && rk_out == '0, "R6 R7 stays idle after code 2", rk_out, '0);

      // R6: commit during expansion restarts from the newer key
      ka = 128'h00112233_44556677_8899aabb_ccddeeff;
      kb = 128'h0f1e2d3c_4b5a6978_8796a5b4_c3d2e1f0;
      push_key(ka);
      commit(2'd1, 1'b0);
      push_key(kb);
      chk(!enc_ready, "R6 still expanding", {127'd0, enc_ready}, '0);
      ref_expand('0, kb, 1'b0);
      commit(2'd1, 1'b0);
      wait_ready(cnt);
      check_lat(cnt, 10, "R6 R5 latency from second commit");
      check_pass(1'b0, "R6 schedule of second key");

      // R6: code 1 on a ready store clears flags at once
      commit(2'd1, 1'b0);
      chk(!enc_ready, "R6 code 1 drops flags", {127'd0, enc_ready}, '0);
      wait_ready(cnt);
      check_lat(cnt, 10, "R5 latency recommit");

      // sweep of random keys in both sizes
      for (int n = 0; n < 6; n++) begin
         ka = {rnd(), rnd(), rnd(), rnd()};
         ref_expand('0, ka, 1'b0);
         push_key(ka);
         commit(2'd1, 1'b0);
         wait_ready(cnt);
         check_lat(cnt, 10, "R5 sweep latency 128");
         check_pass(n[0], "R4 R9 sweep 128");
      end
      for (int n = 0; n < 6; n++) begin
         ka = {rnd(), rnd(), rnd(), rnd()};
         kb = {rnd(), rnd(), rnd(), rnd()};
         ref_expand(ka, kb, 1'b1);
         push_key(ka);
         commit(2'd2, 1'b0);
         push_key(kb);
         commit(2'd1, 1'b1);
         wait_ready(cnt);
         check_lat(cnt, 13, "R5 sweep latency 256");
         check_pass(n[0], "R4 R9 sweep 256");
      end

      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule